// File: doc/BRIEF.md
# Register Decoding Test Sequencer

This block tests the address decoding of an N-entry register file, each entry W bits wide. It drives the write and read ports of the register file. The test looks for decode faults: an access that selects no register, or an access that reaches other registers besides the one addressed. The block keeps a growing set of registers that have already been checked. Registers join this set one at a time, in ascending index order. On pass p, the sequencer first rewrites every checked register (index below p) with the all-ones word. It then writes the all-zeros word to candidate register p. Next it reads all of registers 0 to p back in ascending order and compares each word with its expected value. After that, register p joins the checked set. The run ends after the pass for the highest index.

The block starts on a one-cycle start pulse. While a run is in progress, further start pulses have no effect. The block drives the register file with at most one operation per cycle, and operations follow each other without gaps. The register-file port is a plain memory port, not a stream. It has no valid/ready handshake and gives no back-pressure: the register file must accept a write in the same cycle it is issued, and it must return read data exactly one cycle after the read address. On the first mismatch the block sets a sticky fail flag and records the index of the register that was read. The run still goes on to the end and then finishes with a one-cycle done pulse.

Top module: `regdec_seq`

## Requirements
- R1: After reset, busy, done, fail, rf_wr_en and rf_rd_en are all 0.
- R2: At most one of rf_wr_en and rf_rd_en is high in any cycle. From the cycle after an accepted start until the last read of the final pass, exactly one of them is high in every cycle.
- R3: Pass p (p = 0 to N-1) begins with p+1 consecutive write cycles to addresses 0, 1, ..., p. The write data is the all-ones word for addresses below p and the all-zeros word for address p.
- R4: After the writes of pass p come p+1 consecutive read cycles to addresses 0, 1, ..., p. The word on rf_rd_data is taken one cycle after its address was presented. Pass p+1 begins in the cycle after the last read of pass p.
- R5: A read from an address below the current pass index must return all ones, and a read from the pass index itself must return all zeros. Any other value sets fail, and fail stays set until the next accepted start.
- R6: fail_idx holds the address of the first mismatching read of the run. Later mismatches in the same run do not change it.
- R7: A mismatch does not shorten or change the sequence of operations.
- R8: done is high for exactly one cycle, two cycles after the last read of the final pass is issued. busy is high from the cycle after an accepted start through the done cycle, and is low in the cycle after done.
- R9: A start pulse while busy is high is ignored: the ongoing run keeps its operation order and its done timing.
- R10: One run issues exactly N(N+1)/2 writes and N(N+1)/2 reads.
- R11: An accepted start clears fail and fail_idx.
- R12: The three decode faults below are each reported at a known index:
  - a write to index k that reaches no register is reported at k;
  - a read of index a that returns the contents of another register is reported at a;
  - a write to index a that also reaches a lower index b is reported at b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run; ignored while busy |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Sticky mismatch flag for the current or last run |
| fail_idx | output | AW | Address of the first mismatching read |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_addr | output | AW | Register-file write address |
| rf_wr_data | output | W | Register-file write data (all ones or all zeros) |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rd_addr | output | AW | Register-file read address |
| rf_rd_data | input | W | Register-file read data, valid one cycle after rf_rd_en |

## Verification
The block is run against a register-file model with no fault. This confirms the exact cycle-by-cycle order of operations, the operation totals and a clean result. A run with a start pulse injected mid-sequence shows that a second start cannot restart or stretch a run. Every single-index lost write and every ordered pair of read aliasing is injected in turn, along with every write that also reaches a lower index. For each one the exact fail index predicted by the pass order is checked, which separates the fault classes from one another. Pairs of lost writes show that the first index found is the one kept and that the run still completes in full.

// File: rtl/regdec_pkg.sv
package regdec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WR    = 3'd1,
    ST_RD    = 3'd2,
    ST_DRAIN = 3'd3,
    ST_FIN   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/regdec_ctrl.sv
module regdec_ctrl
  import regdec_pkg::*;
#(
  parameter int NREG = 6,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          launch,
  output logic          busy,
  output logic          done,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_zero,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_zero
);

  localparam logic [AW-1:0] LAST_IDX = AW'(NREG - 1);

  seq_state_e    state_q;
  logic [AW-1:0] pass_q;
  logic [AW-1:0] idx_q;
  logic          at_cand;

  assign at_cand = (idx_q == pass_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_WR;
            pass_q  <= '0;
            idx_q   <= '0;
          end
        end
        ST_WR: begin
          if (at_cand) begin
            idx_q   <= '0;
            state_q <= ST_RD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_RD: begin
          if (at_cand) begin
            idx_q <= '0;
            if (pass_q == LAST_IDX) begin
              state_q <= ST_DRAIN;
            end else begin
              pass_q  <= pass_q + 1'b1;
              state_q <= ST_WR;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_DRAIN: state_q <= ST_FIN;
        ST_FIN:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    launch  = (state_q == ST_IDLE) && start;
    busy    = (state_q != ST_IDLE);
    done    = (state_q == ST_FIN);
    wr_en   = (state_q == ST_WR);
    wr_addr = idx_q;
    wr_zero = at_cand;
    rd_en   = (state_q == ST_RD);
    rd_addr = idx_q;
    rd_zero = at_cand;
  end

  // R2
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  // R3
  wr_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |-> ($past(wr_en) && wr_addr == $past(wr_addr) + 1'b1));

  // R4
  rd_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != '0) |-> ($past(rd_en) && rd_addr == $past(rd_addr) + 1'b1));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(wr_en && wr_addr == '0 && pass_q == '0));

endmodule

// File: rtl/regdec_check.sv
module regdec_check #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_zero,
  input  logic [W-1:0]  rd_data,
  output logic          fail,
  output logic [AW-1:0] fail_idx
);

  localparam logic [W-1:0] WORD_ONE  = {W{1'b1}};
  localparam logic [W-1:0] WORD_ZERO = {W{1'b0}};

  logic          pend_q;
  logic          pend_zero_q;
  logic [AW-1:0] pend_idx_q;
  logic          mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_zero_q <= 1'b0;
      pend_idx_q  <= '0;
    end else begin
      pend_q      <= rd_en;
      pend_zero_q <= rd_zero;
      pend_idx_q  <= rd_addr;
    end
  end

  always_comb begin
    mismatch = 1'b0;
    if (pend_q) begin
      mismatch = pend_zero_q ? (rd_data != WORD_ZERO) : (rd_data != WORD_ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail     <= 1'b0;
      fail_idx <= '0;
    end else if (clear) begin
      fail     <= 1'b0;
      fail_idx <= '0;
    end else if (mismatch && !fail) begin
      fail     <= 1'b1;
      fail_idx <= pend_idx_q;
    end
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !clear) |=> fail);

  // R6
  first_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> (fail && $stable(fail_idx)));

endmodule

// File: rtl/regdec_seq.sv
module regdec_seq #(
  parameter int NREG = 6,
  parameter int W    = 8,
  parameter int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_idx,
  output logic          rf_wr_en,
  output logic [AW-1:0] rf_wr_addr,
  output logic [W-1:0]  rf_wr_data,
  output logic          rf_rd_en,
  output logic [AW-1:0] rf_rd_addr,
  input  logic [W-1:0]  rf_rd_data
);

  logic launch;
  logic wr_zero;
  logic rd_zero;

  regdec_ctrl #(.NREG(NREG), .AW(AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .launch  (launch),
    .busy    (busy),
    .done    (done),
    .wr_en   (rf_wr_en),
    .wr_addr (rf_wr_addr),
    .wr_zero (wr_zero),
    .rd_en   (rf_rd_en),
    .rd_addr (rf_rd_addr),
    .rd_zero (rd_zero)
  );

  assign rf_wr_data = wr_zero ? {W{1'b0}} : {W{1'b1}};

  regdec_check #(.W(W), .AW(AW)) u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (launch),
    .rd_en    (rf_rd_en),
    .rd_addr  (rf_rd_addr),
    .rd_zero  (rd_zero),
    .rd_data  (rf_rd_data),
    .fail     (fail),
    .fail_idx (fail_idx)
  );

  // R3
  wr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && rf_wr_data != {W{1'b0}}) |-> (rf_wr_data == {W{1'b1}}));

endmodule

// File: tb/regdec_seq_test.sv
`timescale 1ns/1ps
module regdec_seq_test;

  localparam int N  = 6;
  localparam int W  = 8;
  localparam int AW = 3;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, fail;
  logic [AW-1:0] fail_idx;
  logic          rf_wr_en, rf_rd_en;
  logic [AW-1:0] rf_wr_addr, rf_rd_addr;
  logic [W-1:0]  rf_wr_data;
  logic [W-1:0]  rf_rd_data;

  // register-file model with injectable decode faults
  // mode 0 none, 1 write to fa lost, 2 write to fa also hits fb,
  // 3 read of fa returns fb, 4 writes to fa and fb lost
  int   fmode = 0;
  int   ffa = 0;
  int   ffb = 0;
  logic clr = 1'b0;
  logic [W-1:0] mem [N];

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  regdec_seq #(.NREG(N), .W(W), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .fail(fail), .fail_idx(fail_idx),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data)
  );

  always @(posedge clk) begin
    if (clr) begin
      for (int j = 0; j < N; j++) mem[j] <= ONES;
    end else begin
      if (rf_wr_en) begin
        if (!((fmode == 1 || fmode == 4) && int'(rf_wr_addr) == ffa) &&
            !(fmode == 4 && int'(rf_wr_addr) == ffb))
          mem[rf_wr_addr] <= rf_wr_data;
        if (fmode == 2 && int'(rf_wr_addr) == ffa)
          mem[ffb] <= rf_wr_data;
      end
    end
    if (rf_rd_en)
      rf_rd_data <= (fmode == 3 && int'(rf_rd_addr) == ffa) ? mem[ffb] : mem[rf_rd_addr];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input int mode, input int fa, input int fb, input bit poke,
                         input bit exp_fail, input int exp_idx);
    int seq_err = 0;
    int wcnt = 0;
    int rcnt = 0;
    fmode = mode; ffa = fa; ffb = fb;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R11: cleared by the accepted start
    check(fail == 1'b0 && fail_idx == '0, "R11", "flag cleared at start", int'(fail), 0);
    for (int p = 0; p < N; p++) begin
      for (int i = 0; i <= p; i++) begin
        wcnt += int'(rf_wr_en); rcnt += int'(rf_rd_en);
        if (!(rf_wr_en && !rf_rd_en && busy && !done && int'(rf_wr_addr) == i &&
              rf_wr_data == ((i == p) ? '0 : ONES)))
          seq_err++;
        start = poke && (p == 2) && (i == 0);
        @(negedge clk);
        start = 1'b0;
      end
      for (int i = 0; i <= p; i++) begin
        wcnt += int'(rf_wr_en); rcnt += int'(rf_rd_en);
        if (!(rf_rd_en && !rf_wr_en && busy && !done && int'(rf_rd_addr) == i))
          seq_err++;
        @(negedge clk);
      end
    end
    wcnt += int'(rf_wr_en); rcnt += int'(rf_rd_en);
    if (rf_wr_en || rf_rd_en || done || !busy) seq_err++;
    @(negedge clk);
    wcnt += int'(rf_wr_en); rcnt += int'(rf_rd_en);
    check(done == 1'b1 && busy == 1'b1, poke ? "R9" : "R8", "done at end", int'(done), 1);
    check(fail == exp_fail, "R5", "fail flag", int'(fail), int'(exp_fail));
    if (exp_fail)
      check(int'(fail_idx) == exp_idx, "R12", "fail index", int'(fail_idx), exp_idx);
    @(negedge clk);
    check(!done && !busy, "R8", "done one cycle", int'(done), 0);
    check(seq_err == 0, "R3 R4 R7", "operation order errors", seq_err, 0);
    check(wcnt == N*(N+1)/2, "R10", "write count", wcnt, N*(N+1)/2);
    check(rcnt == N*(N+1)/2, "R10", "read count", rcnt, N*(N+1)/2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !fail && !rf_wr_en && !rf_rd_en, "R1", "reset state",
          int'({busy, done, fail, rf_wr_en, rf_rd_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !rf_wr_en && !rf_rd_en, "R1", "idle after reset", int'(busy), 0);

    run_seq(0, 0, 0, 1'b0, 1'b0, 0);
    // R9: start mid-run
    run_seq(0, 0, 0, 1'b1, 1'b0, 0);
    // R12: lost writes
    for (int k = 0; k < N; k++) run_seq(1, k, 0, 1'b0, 1'b1, k);
    // R12: read aliasing
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        if (a != b) run_seq(3, a, b, 1'b0, 1'b1, a);
    // R12: extra write reaching a lower index
    for (int a = 1; a < N; a++)
      for (int b = 0; b < a; b++) run_seq(2, a, b, 1'b0, 1'b1, b);
    // R6 R7: two lost writes, first index kept
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++) run_seq(4, a, b, 1'b0, 1'b1, a);
    // R11: clean run after failing ones
    run_seq(0, 0, 0, 1'b0, 1'b0, 0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule